// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command logic of a parallel NOR-style flash model with a 16-bit word bus. It watches host write cycles, which carry an address and data. It tracks a six-write keyed sequence that unlocks and requests a whole-array erase. The address keys depend on a byte-addressing strap. When the sixth write matches, the block starts a self-timed erase and needs nothing more from the host. The erase first writes zero into every word of the array, one word per clock. It then writes all ones into every word, again one word per clock.

While the erase runs, the block raises `busy` and ignores every write. Reads during this time return a status word: bit 7 is low and bit 6 alternates from one read to the next. When the erase ends, `erase_done` pulses for one cycle and reads return array contents again. An asynchronous hardware reset stops the erase at once. Any words the erase has not reached keep the values they had at that moment.

Top module: `flash_cmd_ctl`

## Requirements
- R1: In word mode (`byte_mode`=0) the accepted writes are, in order, (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), (555h,10h). Each write is an address and the low data byte; the upper data byte is not compared. `busy` is high in the cycle after the clock edge that accepts the sixth write.
- R2: In byte mode (`byte_mode`=1), key address AAAh takes the place of 555h and 555h takes the place of 2AAh. Word-mode key addresses do not start an erase while byte mode is set.
- R3: A write that does not match the expected address and low byte returns the tracker to waiting for the first unlock write. The rest of that sequence then does not start an erase.
- R4: `busy` stays high for exactly 2*2^ARR_AW clock cycles. `erase_done` is high for exactly one cycle, which is the first cycle with `busy` low.
- R5: After an erase completes, every word reads FFFFh. A read selects word `bus_addr[ARR_AW-1:0]` in word mode and `bus_addr[ARR_AW:1]` in byte mode.
- R6: The erase first writes 0000h into words 0, 1, 2 and so on, one word per cycle. Only after that pass does it write FFFFh into words 0, 1, 2 and so on, one word per cycle.
- R7: Writes while `busy` is high are ignored. They do not lengthen the erase, do not start a second one, and do not advance the tracker.
- R8: A read while `busy` is high returns a status word. All bits are zero except bit 6. Bit 6 is 0 on the first read after the erase starts and inverts on each later read.
- R9: Driving `rst_n` low at once clears `busy`, `erase_done` and `bus_rdata` and returns the tracker to its first write. The array keeps its contents.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_re` is sampled. It holds until the next read.
- R11: Reads placed between the writes of a sequence do not disturb the tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| byte_mode | input | 1 | Selects byte-mode key addresses and read indexing |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_re | input | 1 | Host read strobe, one cycle per read |
| bus_addr | input | ADDR_W (12) | Host address |
| bus_wdata | input | DATA_W (16) | Host write data |
| bus_rdata | output | DATA_W (16) | Registered read data or status word |
| busy | output | 1 | High while the erase runs |
| erase_done | output | 1 | One-cycle pulse when the erase finishes |

## Verification
The assertions assume that `byte_mode` is steady for the whole of a sequence and its erase. They also assume that each strobe lasts one cycle. The bench changes `byte_mode` only while the block is idle and the tracker is back at its first write. It drives each write and each read as a single-cycle pulse from the falling edge. It releases reset on a falling edge, so no strobe and no reset edge share a rising clock edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_PREP  = 2'd1,
        ENG_ERASE = 2'd2
    } eng_state_e;

    localparam int SEQ_LEN = 6;

    localparam logic [11:0] WORD_KEY_P = 12'h555;
    localparam logic [11:0] WORD_KEY_S = 12'h2AA;
    localparam logic [11:0] BYTE_KEY_P = 12'hAAA;
    localparam logic [11:0] BYTE_KEY_S = 12'h555;

    // Low data byte expected at each step of the sequence.
    function automatic logic [7:0] step_data(input logic [2:0] step);
        case (step)
            3'd0:    return 8'hAA;
            3'd1:    return 8'h55;
            3'd2:    return 8'h80;
            3'd3:    return 8'hAA;
            3'd4:    return 8'h55;
            default: return 8'h10;
        endcase
    endfunction

    // Steps 1 and 4 use the secondary key address, the rest the primary one.
    function automatic logic step_is_primary(input logic [2:0] step);
        return !(step == 3'd1 || step == 3'd4);
    endfunction

endpackage

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              start
);

    localparam logic [2:0] LAST_STEP = 3'(SEQ_LEN - 1);

    typedef struct packed {
        logic [2:0] step;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [ADDR_W-1:0] exp_addr;
    logic              hit;

    always_comb begin
        trk_d = trk_q;
        start = 1'b0;
        if (step_is_primary(trk_q.step))
            exp_addr = ADDR_W'(byte_mode ? BYTE_KEY_P : WORD_KEY_P);
        else
            exp_addr = ADDR_W'(byte_mode ? BYTE_KEY_S : WORD_KEY_S);
        hit = (wr_addr == exp_addr) && (wr_data[7:0] == step_data(trk_q.step));
        if (wr_en && !busy) begin
            if (!hit) begin
                trk_d.step = 3'd0;
            end else if (trk_q.step == LAST_STEP) begin
                trk_d.step = 3'd0;
                start      = 1'b1;
            end else begin
                trk_d.step = trk_q.step + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.step <= LAST_STEP); // R3
    AST_STEP_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(trk_q.step)); // R7
    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R7

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
    import flash_cmd_pkg::*;
#(
    parameter int ARR_AW = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              arr_we,
    output logic [ARR_AW-1:0] arr_idx,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam logic [ARR_AW-1:0] LAST_IDX = '1;

    typedef struct packed {
        eng_state_e        st;
        logic [ARR_AW-1:0] ptr;
        logic              done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        arr_we     = 1'b0;
        arr_wdata  = '0;
        case (eng_q.st)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.st  = ENG_PREP;
                    eng_d.ptr = '0;
                end
            end
            ENG_PREP: begin
                arr_we    = 1'b1;
                arr_wdata = '0;
                if (eng_q.ptr == LAST_IDX) begin
                    eng_d.st  = ENG_ERASE;
                    eng_d.ptr = '0;
                end else begin
                    eng_d.ptr = eng_q.ptr + 1'b1;
                end
            end
            ENG_ERASE: begin
                arr_we    = 1'b1;
                arr_wdata = '1;
                if (eng_q.ptr == LAST_IDX) begin
                    eng_d.st   = ENG_IDLE;
                    eng_d.ptr  = '0;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.ptr = eng_q.ptr + 1'b1;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, ptr: '0, done: 1'b0};
        else        eng_q <= eng_d;
    end

    assign busy    = (eng_q.st != ENG_IDLE);
    assign done    = eng_q.done;
    assign arr_idx = eng_q.ptr;

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> eng_q.st == ENG_IDLE); // R7
    AST_ERASE_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_ERASE && $past(eng_q.st) != ENG_ERASE) |-> $past(eng_q.st) == ENG_PREP); // R6
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ARR_AW = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ARR_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ARR_AW-1:0] rd_idx,
    input  logic              busy,
    input  logic              start,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH      = 1 << ARR_AW;
    localparam int TOGGLE_BIT = 6;
    localparam int POLL_BIT   = 7;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              tog;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // Storage has no reset: a hardware reset must leave contents as they are.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_comb begin
        rd_d = rd_q;
        if (start) rd_d.tog = 1'b0;
        if (rd_en) begin
            if (busy) begin
                rd_d.rdata             = '0;
                rd_d.rdata[TOGGLE_BIT] = rd_q.tog;
                rd_d.tog               = ~rd_q.tog;
            end else begin
                rd_d.rdata = mem[rd_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.rdata;

    AST_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> rd_q.rdata[POLL_BIT] == 1'b0); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q.rdata)); // R10
    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R6

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int ARR_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              erase_done
);

    logic              start;
    logic              arr_we;
    logic [ARR_AW-1:0] arr_idx;
    logic [DATA_W-1:0] arr_wdata;
    logic [ARR_AW-1:0] rd_idx;

    assign rd_idx = byte_mode ? bus_addr[ARR_AW:1] : bus_addr[ARR_AW-1:0];

    flash_seq_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .busy(busy), .start(start)
    );

    flash_erase_engine #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(erase_done),
        .arr_we(arr_we), .arr_idx(arr_idx), .arr_wdata(arr_wdata)
    );

    flash_array #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(arr_we), .wr_idx(arr_idx), .wr_data(arr_wdata),
        .rd_en(bus_re), .rd_idx(rd_idx), .busy(busy), .start(start),
        .rd_data(bus_rdata)
    );

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R1
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> !busy); // R4

endmodule

// File: tb/flash_cmd_ctl_bench.sv
module flash_cmd_ctl_bench;

    localparam int ARR_AW = 4;
    localparam int DEPTH  = 1 << ARR_AW;
    localparam int BUSY_CYCLES = 2 * DEPTH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        busy;
    logic        erase_done;

    int tests = 0;
    int fails = 0;
    int busy_ctr = 0;
    int done_ctr = 0;

    always #4 clk = ~clk;

    flash_cmd_ctl #(.ADDR_W(12), .DATA_W(16), .ARR_AW(ARR_AW)) u_flash_cmd_ctl (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .erase_done(erase_done)
    );

    always @(negedge clk) begin
        if (busy) busy_ctr <= busy_ctr + 1;
        if (erase_done) done_ctr <= done_ctr + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] key_addr(input int i, input bit bm);
        bit prim = !(i == 1 || i == 4);
        if (bm) return prim ? 12'hAAA : 12'h555;
        return prim ? 12'h555 : 12'h2AA;
    endfunction

    function automatic logic [7:0] key_data(input int i);
        case (i)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            2:       return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic seq(input bit bm, input bit reads_between, input logic [7:0] hi);
        logic [15:0] junk;
        for (int i = 0; i < 6; i++) begin
            wr(key_addr(i, bm), {hi, key_data(i)});
            if (reads_between && i < 5) rd(12'h003, junk);
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 1000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        #1;
        chk("R9 busy cleared by reset", busy, 0);
        chk("R9 done cleared by reset", erase_done, 0);
        chk("R9 rdata cleared by reset", bus_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        chk("R9 busy low in reset", busy, 0);
        chk("R9 rdata zero in reset", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Full erase in word mode
        busy_ctr = 0; done_ctr = 0;
        seq(0, 0, 8'h00);
        chk("R1 busy after sixth write", busy, 1);
        rd(12'h000, v); chk("R8 status read 1", v, 16'h0000);
        rd(12'h000, v); chk("R8 status read 2", v, 16'h0040);
        rd(12'h000, v); chk("R8 status read 3", v, 16'h0000);
        wait_idle();
        chk("R4 done pulse at busy fall", erase_done, 1);
        @(negedge clk);
        chk("R4 done pulse one cycle", erase_done, 0);
        chk("R4 busy cycle count", busy_ctr, BUSY_CYCLES);
        chk("R4 single done", done_ctr, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(12'(i), v); chk("R5 erased word", v, 16'hFFFF);
        end
        rd(12'h003, v);
        repeat (3) @(negedge clk);
        chk("R10 rdata holds", bus_rdata, 16'hFFFF);

        // Reset during preprogram after five words
        seq(0, 0, 8'h00);
        repeat (5) @(negedge clk);
        hw_reset();
        for (int i = 0; i < DEPTH; i++) begin
            rd(12'(i), v); chk("R6 preprogram abort", v, (i < 5) ? 16'h0000 : 16'hFFFF);
        end

        // Reset during erase pass after three words
        seq(0, 0, 8'h00);
        repeat (DEPTH + 3) @(negedge clk);
        hw_reset();
        for (int i = 0; i < DEPTH; i++) begin
            rd(12'(i), v); chk("R6 erase abort", v, (i < 3) ? 16'hFFFF : 16'h0000);
        end

        // Wrong cycle sweep: every position, bad address or bad data
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 2; k++) begin
                for (int i = 0; i < 6; i++) begin
                    logic [11:0] a = key_addr(i, 0);
                    logic [15:0] d = {8'h00, key_data(i)};
                    if (i == p && k == 0) a = a ^ 12'h001;
                    if (i == p && k == 1) d = d ^ 16'h0001;
                    wr(a, d);
                end
                @(negedge clk);
                chk("R3 corrupted sequence ignored", busy, 0);
            end
        end

        // Reset mid-sequence returns tracker to the first write
        for (int i = 0; i < 3; i++) wr(key_addr(i, 0), {8'h00, key_data(i)});
        hw_reset();
        for (int i = 3; i < 6; i++) wr(key_addr(i, 0), {8'h00, key_data(i)});
        @(negedge clk);
        chk("R9 tracker restarted by reset", busy, 0);

        // Byte mode: word keys rejected
        byte_mode = 1'b1;
        @(negedge clk);
        seq(0, 0, 8'h00);
        @(negedge clk);
        chk("R2 word keys rejected in byte mode", busy, 0);

        // Byte mode with interleaved reads and junk upper byte
        busy_ctr = 0; done_ctr = 0;
        seq(1, 1, 8'hA5);
        chk("R2 R11 byte-mode start with reads between", busy, 1);
        seq(1, 0, 8'h00);
        chk("R7 still busy after writes", busy, 1);
        wait_idle();
        @(negedge clk);
        chk("R7 busy not extended", busy_ctr, BUSY_CYCLES);
        chk("R7 no second erase", done_ctr, 1);
        wr(key_addr(5, 1), 16'h0010);
        @(negedge clk);
        chk("R7 tracker not advanced while busy", busy, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(12'(i << 1), v); chk("R5 byte-mode read of erased word", v, 16'hFFFF);
        end
        byte_mode = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule